// File: doc/BRIEF.md
# Memory Operation Issue Selector

This block chooses, every cycle, which memory operation in an out-of-order core's load/store window may issue. The window is a circular set of entries. A head pointer marks the oldest entry, and age increases with the index, wrapping around the end. Each entry reports whether it is valid, whether it is a store, whether its address part is ready, whether its data part is ready, and whether it has already issued. The block returns a one-hot grant that names at most one entry.

Every store has two parts, an address part and a data part, and each part has its own ready flag. For a load, the address-ready flag means that its operands are ready, and the data-ready flag is not used. A two-bit ordering policy decides how far loads may pass older stores:

- **In-order:** only the head may issue.
- **Stores fence:** any older store that has not issued blocks everything younger.
- **Wait for addresses:** a load waits only until the addresses of older stores are known.
- **Free loads:** loads never wait for stores.

The block registers the policy input only while no valid entry is marked issued, so the policy cannot change under operations that are in flight.

Top module: `mem_issue_sel`

## Requirements
- R1: `grant_o` has at most one bit set, and it is all zeros when no entry is eligible.
- R2: A load is a candidate when it is valid, not issued and address-ready, whatever its data-ready flag. A store is a candidate only when it is valid, not issued, address-ready and data-ready.
- R3: Among the eligible entries, the grant goes to the one nearest the head, counting upward from `head_i` and wrapping from the last index to index 0.
- R4: Policy code 0 (in-order) grants only the entry at `head_i`. If the head is not a candidate, nothing is granted.
- R5: Under policy code 1, a valid, unissued store blocks every younger entry. Loads that are not blocked may issue out of order with respect to each other.
- R6: Under policy code 2, a load is blocked only by an older valid, unissued store whose address is not ready. The data-ready flag of an older store has no effect on a load.
- R7: Under policy code 3, a load candidate is never blocked by any older store.
- R8: Under policy codes 1, 2 and 3, a store is blocked by any older valid, unissued store.
- R9: The policy in use resets to code 0. The block loads `policy_i` at a clock edge only when no entry is both valid and issued. Otherwise it keeps the previous policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Requested ordering policy code (0 to 3) |
| head_i | input | IDX_W | Index of the oldest entry |
| valid_i | input | ENTRIES | Entry holds a memory operation |
| is_store_i | input | ENTRIES | 1 = store, 0 = load |
| addr_rdy_i | input | ENTRIES | Address part ready (operands ready for a load) |
| data_rdy_i | input | ENTRIES | Store data part ready |
| issued_i | input | ENTRIES | Entry has already issued |
| grant_o | output | ENTRIES | One-hot issue grant |

## Verification
The bench targets the cases that separate the four policies.

- **Store with address but no data, younger load:** this must let the load through under the address-wait policy and block it under the fence policy. A design that tests the wrong ready flag stalls the load or lets it through at the wrong time.
- **Window that wraps past the last index:** a picker that scans from index 0 instead of from the head grants a younger entry.
- **Store blocked behind a pending store under the free-load policy:** this catches stores that are allowed to pass each other.
- **Policy change while an entry is in flight:** a register that loads without the busy gate switches discipline under issued operations, and the bench sees a grant appear or vanish.

// File: rtl/mis_pkg.sv
package mis_pkg;
    typedef enum logic [1:0] {
        POL_INORDER  = 2'd0,
        POL_ST_FENCE = 2'd1,
        POL_STA_WAIT = 2'd2,
        POL_FREE     = 2'd3
    } policy_e;

    typedef struct packed {
        policy_e policy;
    } sel_state_t;
endpackage

// File: rtl/mis_age_view.sv
// Rotates a per-entry vector so that bit 0 is the head (oldest) entry.
module mis_age_view #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0]   head_i,
    input  logic [ENTRIES-1:0] vec_i,
    output logic [ENTRIES-1:0] age_o
);
    for (genvar k = 0; k < ENTRIES; k++) begin : g_rot
        logic [IDX_W-1:0] src;
        assign src      = head_i + IDX_W'(k);
        assign age_o[k] = vec_i[src];
    end
endmodule

// File: rtl/mis_elig.sv
// Applies the ordering policy to age-ordered flags.
module mis_elig
    import mis_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  policy_e            policy_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] store_i,
    input  logic [ENTRIES-1:0] ardy_i,
    input  logic [ENTRIES-1:0] drdy_i,
    input  logic [ENTRIES-1:0] issued_i,
    output logic [ENTRIES-1:0] elig_o
);
    logic [ENTRIES-1:0] cand;
    logic [ENTRIES-1:0] st_pend;      // unissued store present
    logic [ENTRIES-1:0] sta_pend;     // unissued store without address
    logic [ENTRIES-1:0] older_st;
    logic [ENTRIES-1:0] older_sta;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_cand
        assign cand[k]     = valid_i[k] && !issued_i[k] && ardy_i[k] &&
                             (!store_i[k] || drdy_i[k]);
        assign st_pend[k]  = valid_i[k] && store_i[k] && !issued_i[k];
        assign sta_pend[k] = st_pend[k] && !ardy_i[k];
    end

    always_comb begin
        older_st  = '0;
        older_sta = '0;
        for (int k = 1; k < ENTRIES; k++) begin
            older_st[k]  = older_st[k-1]  | st_pend[k-1];
            older_sta[k] = older_sta[k-1] | sta_pend[k-1];
        end
    end

    always_comb begin
        elig_o = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            unique case (policy_i)
                POL_INORDER:  elig_o[k] = (k == 0) && cand[k];
                POL_ST_FENCE: elig_o[k] = cand[k] && !older_st[k];
                POL_STA_WAIT: elig_o[k] = cand[k] &&
                                          (store_i[k] ? !older_st[k] : !older_sta[k]);
                POL_FREE:     elig_o[k] = cand[k] && (!store_i[k] || !older_st[k]);
                default:      elig_o[k] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mis_pick.sv
// Picks the oldest eligible entry and maps it back to its physical index.
module mis_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0]   head_i,
    input  logic [ENTRIES-1:0] elig_i,
    output logic [ENTRIES-1:0] grant_o
);
    logic [ENTRIES-1:0] sel;
    logic               found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (elig_i[k] && !found) begin
                sel[k] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    always_comb begin
        grant_o = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            grant_o[head_i + IDX_W'(k)] = sel[k];
        end
    end
endmodule

// File: rtl/mem_issue_sel.sv
module mem_issue_sel
    import mis_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_i,
    input  logic [IDX_W-1:0]   head_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] is_store_i,
    input  logic [ENTRIES-1:0] addr_rdy_i,
    input  logic [ENTRIES-1:0] data_rdy_i,
    input  logic [ENTRIES-1:0] issued_i,
    output logic [ENTRIES-1:0] grant_o
);
    sel_state_t st_d, st_q;
    logic       busy;

    logic [ENTRIES-1:0] a_valid, a_store, a_ardy, a_drdy, a_issued, a_elig;

    assign busy = |(valid_i & issued_i);

    always_comb begin
        st_d = st_q;
        if (!busy) st_d.policy = policy_e'(policy_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{policy: POL_INORDER};
        else        st_q <= st_d;
    end

    mis_age_view #(.ENTRIES(ENTRIES)) u_av_valid (.head_i(head_i), .vec_i(valid_i),    .age_o(a_valid));
    mis_age_view #(.ENTRIES(ENTRIES)) u_av_store (.head_i(head_i), .vec_i(is_store_i), .age_o(a_store));
    mis_age_view #(.ENTRIES(ENTRIES)) u_av_ardy  (.head_i(head_i), .vec_i(addr_rdy_i), .age_o(a_ardy));
    mis_age_view #(.ENTRIES(ENTRIES)) u_av_drdy  (.head_i(head_i), .vec_i(data_rdy_i), .age_o(a_drdy));
    mis_age_view #(.ENTRIES(ENTRIES)) u_av_iss   (.head_i(head_i), .vec_i(issued_i),   .age_o(a_issued));

    mis_elig #(.ENTRIES(ENTRIES)) u_elig (
        .policy_i (st_q.policy),
        .valid_i  (a_valid),
        .store_i  (a_store),
        .ardy_i   (a_ardy),
        .drdy_i   (a_drdy),
        .issued_i (a_issued),
        .elig_o   (a_elig)
    );

    mis_pick #(.ENTRIES(ENTRIES)) u_pick (
        .head_i  (head_i),
        .elig_i  (a_elig),
        .grant_o (grant_o)
    );

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2
    grant_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~(valid_i & ~issued_i & addr_rdy_i)) == '0);

    // R2
    store_both_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & is_store_i & ~data_rdy_i) == '0);

    // R4
    inorder_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.policy == POL_INORDER && grant_o != '0) |->
        grant_o == (ENTRIES'(1) << head_i));

    // R9
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> st_q.policy == $past(st_q.policy));
endmodule

// File: tb/mem_issue_sel_tb.sv
module mem_issue_sel_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   policy_i = 2'd0;
    logic [2:0]   head_i = '0;
    logic [N-1:0] valid_i = '0, is_store_i = '0, addr_rdy_i = '0, data_rdy_i = '0, issued_i = '0;
    logic [N-1:0] grant_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    mem_issue_sel #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .head_i(head_i),
        .valid_i(valid_i), .is_store_i(is_store_i), .addr_rdy_i(addr_rdy_i),
        .data_rdy_i(data_rdy_i), .issued_i(issued_i), .grant_o(grant_o)
    );

    task automatic check(string req, logic [N-1:0] exp);
        #1;
        total++;
        if (grant_o !== exp) begin
            bad++;
            $display("FAIL %s: grant=%b expected=%b", req, grant_o, exp);
        end
    endtask

    task automatic drive(logic [2:0] h, logic [N-1:0] v, logic [N-1:0] s,
                         logic [N-1:0] a, logic [N-1:0] d, logic [N-1:0] i);
        head_i = h; valid_i = v; is_store_i = s;
        addr_rdy_i = a; data_rdy_i = d; issued_i = i;
    endtask

    task automatic set_policy(logic [1:0] p);
        @(negedge clk);
        drive(3'd0, '0, '0, '0, '0, '0);
        policy_i = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        drive(3'd0, '0, '0, '0, '0, '0);
        check("R1", 8'b0);
        // R9: reset policy is in-order; head 3 not ready, entry 4 ready
        drive(3'd3, 8'b0001_1000, '0, 8'b0001_0000, '0, '0);
        check("R9", 8'b0);
    endtask

    task automatic t_ready;
        set_policy(2'd3);
        // R2: store 0 lacks data, load 1 not ready, load 2 ready
        drive(3'd0, 8'b0000_0111, 8'b0000_0001, 8'b0000_0101, 8'b0, '0);
        check("R2", 8'b0000_0100);
        drive(3'd0, 8'b0000_0111, 8'b0000_0001, 8'b0000_0101, 8'b0000_0001, '0);
        check("R2", 8'b0000_0001);
    endtask

    task automatic t_wrap;
        set_policy(2'd3);
        drive(3'd6, 8'b1000_0010, '0, 8'b1000_0010, '0, '0);
        check("R3", 8'b1000_0000);
        drive(3'd6, 8'b0010_0010, '0, 8'b0010_0010, '0, '0);
        check("R3", 8'b0000_0010);
    endtask

    task automatic t_inorder;
        set_policy(2'd0);
        drive(3'd2, 8'b0000_1100, '0, 8'b0000_1000, '0, '0);
        check("R4", 8'b0);
        drive(3'd2, 8'b0000_1100, '0, 8'b0000_1100, '0, '0);
        check("R4", 8'b0000_0100);
    endtask

    task automatic t_fence;
        set_policy(2'd1);
        // R5: store 0 without address blocks ready load 1
        drive(3'd0, 8'b0000_0011, 8'b0000_0001, 8'b0000_0010, '0, '0);
        check("R5", 8'b0);
        // R5: store 0 has address but no data: still blocks
        drive(3'd0, 8'b0000_0011, 8'b0000_0001, 8'b0000_0011, '0, '0);
        check("R5", 8'b0);
        // R5: store issued, load 1 not ready, load 2 passes it
        drive(3'd0, 8'b0000_0111, 8'b0000_0001, 8'b0000_0101, 8'b0000_0001, 8'b0000_0001);
        check("R5", 8'b0000_0100);
    endtask

    task automatic t_sta_wait;
        set_policy(2'd2);
        drive(3'd0, 8'b0000_0011, 8'b0000_0001, 8'b0000_0011, '0, '0);
        check("R6", 8'b0000_0010);
        drive(3'd0, 8'b0000_0011, 8'b0000_0001, 8'b0000_0010, 8'b0000_0001, '0);
        check("R6", 8'b0);
    endtask

    task automatic t_free;
        set_policy(2'd3);
        drive(3'd0, 8'b0000_0011, 8'b0000_0001, 8'b0000_0010, '0, '0);
        check("R7", 8'b0000_0010);
        // R8: store 1 ready behind pending store 0; load 2 ready
        drive(3'd0, 8'b0000_0111, 8'b0000_0011, 8'b0000_0110, 8'b0000_0010, '0);
        check("R8", 8'b0000_0100);
        drive(3'd0, 8'b0000_0011, 8'b0000_0011, 8'b0000_0010, 8'b0000_0010, '0);
        check("R8", 8'b0);
    endtask

    task automatic t_hold;
        set_policy(2'd3);
        // busy: entry 0 valid and issued; request in-order
        drive(3'd0, 8'b0000_0111, 8'b0000_0001, 8'b0000_0111, 8'b0000_0001, 8'b0000_0001);
        policy_i = 2'd0;
        @(posedge clk);
        @(negedge clk);
        check("R9", 8'b0000_0010);
        // not busy: in-order now loaded, head 0 invalid -> no grant
        drive(3'd0, 8'b0000_0110, '0, 8'b0000_0110, '0, '0);
        @(posedge clk);
        @(negedge clk);
        check("R9", 8'b0);
    endtask

    initial begin
        #20;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ready();
        t_wrap();
        t_inorder();
        t_fence();
        t_sta_wait();
        t_free();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule